// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a read or write burst inside one open SDRAM row. A single-cycle start pulse captures a starting column, a burst-length code and an ordering bit. From the next clock onward, the block presents one column per cycle, together with a valid flag and a flag that marks the final beat. It stops when the programmed length has been stepped out, or when a terminate input reports a burst-stop or precharge command.

Bursts of fixed length can wrap sequentially inside their aligned block of columns, or they can follow the interleaved (XOR) order. A full-page burst walks the whole row upward and wraps from the top column to zero. It runs until it is terminated or restarted. A start pulse is accepted on any clock, including the middle of a burst, so a new random column restarts the sequence at once. Command decoding, data, refresh and row handling belong to other blocks.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is asserted and after its release, with no start, valid_o and last_o are 0 and col_o is 0.
- R2: A start pulse on clock edge n makes valid_o 1 from edge n+1, and col_o equals start_col_i for beat 0.
- R3: bl_code_i selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100 to 3'b110 give 1 beat. A fixed burst holds valid_o for exactly that many cycles.
- R4: With interleave_i at 0, beat k of a fixed burst of length L has its low log2(L) bits equal to (start + k) mod L. The upper bits stay equal to those of the start column.
- R5: With interleave_i at 1, beat k of a fixed burst of length L equals the start column with its low log2(L) bits XORed with k.
- R6: A full-page burst ignores interleave_i. Each beat is the previous column plus 1 modulo 256, and the burst continues with no end of its own.
- R7: last_o is 1 exactly on the final beat of a fixed burst and is never 1 during a full-page burst or while valid_o is 0.
- R8: term_i on an edge without start_i makes valid_o and last_o 0 from the next cycle. When start_i and term_i arrive together, the start wins.
- R9: A start pulse during a burst restarts the sequence from the new column, with the new length and order, on the next cycle.
- R10: term_i while idle has no effect: valid_o stays 0 and col_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | 8 | Starting column |
| bl_code_i | input | 3 | Burst-length code (see R3) |
| interleave_i | input | 1 | 1 selects interleaved order |
| term_i | input | 1 | Burst stop or precharge seen |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed burst |

## Verification
The bench starts bursts mid-block, for example at 0x05, 0x3E and 0xFF. A generator that carried into the upper column bits, or that mixed up the sequential and XOR orders, would give wrong beats 1 to 7. A full-page burst is started at 0xFE with the interleave bit set. It must cross 0xFF to 0x00 in increasing order, and it is left running past 256 beats, so a design that ended it or raised last_o there is caught. Restarts mid-burst, start with terminate on the same edge, terminate mid-burst, terminate while idle and the reserved length codes are each checked. These expose a stale beat counter, a wrong priority, or a design that decodes the reserved codes as a length other than 1.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT= 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  localparam int unsigned MAX_FIXED_LOG2 = 3;
endpackage

// File: rtl/sdram_col_cfg.sv
// Decodes the length code into a low-bit mask and mode flags.
module sdram_col_cfg #(
  parameter int unsigned COL_W = 8
) (
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);
  import sdram_col_pkg::*;

  logic [2:0] len_log2;

  always_comb begin
    full_o   = 1'b0;
    len_log2 = 3'd0;
    case (bl_code_i)
      BL_ONE:   len_log2 = 3'd0;
      BL_TWO:   len_log2 = 3'd1;
      BL_FOUR:  len_log2 = 3'd2;
      BL_EIGHT: len_log2 = 3'd3;
      BL_PAGE:  full_o   = 1'b1;
      default:  len_log2 = 3'd0;  // reserved codes act as single beat
    endcase
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < MAX_FIXED_LOG2) begin : g_low
      assign mask_o[i] = full_o | (len_log2 > 3'(i));
    end else begin : g_high
      assign mask_o[i] = full_o;
    end
  end

  // full page is sequential only
  assign ilv_o = interleave_i & ~full_o;
endmodule

// File: rtl/sdram_col_ctr.sv
// Burst state: base column, beat index, captured mode, valid.
module sdram_col_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             full_q, ilv_q, valid_q;
  logic             at_end;

  assign at_end = valid_q & ~full_q & (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      idx_q   <= '0;
      mask_q  <= mask_i;
      full_q  <= full_i;
      ilv_q   <= ilv_i;
      valid_q <= 1'b1;
    end else if (term_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (at_end) valid_q <= 1'b0;
      else        idx_q   <= idx_q + COL_W'(1);
    end
  end

  assign base_o  = base_q;
  assign idx_o   = idx_q;
  assign mask_o  = mask_q;
  assign ilv_o   = ilv_q;
  assign valid_o = valid_q;
  assign last_o  = at_end;
endmodule

// File: rtl/sdram_col_gen.sv
// Column from base, beat index and mode.
module sdram_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum, seq_col, ilv_col;

  assign seq_sum = base_i + idx_i;
  assign seq_col = (base_i & ~mask_i) | (seq_sum & mask_i);
  assign ilv_col = base_i ^ (idx_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, base, idx, cur_mask;
  logic             dec_full, dec_ilv, cur_ilv;

  sdram_col_cfg #(.COL_W(COL_W)) u_cfg (
    .bl_code_i   (bl_code_i),
    .interleave_i(interleave_i),
    .mask_o      (dec_mask),
    .full_o      (dec_full),
    .ilv_o       (dec_ilv)
  );

  sdram_col_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .term_i     (term_i),
    .start_col_i(start_col_i),
    .mask_i     (dec_mask),
    .full_i     (dec_full),
    .ilv_i      (dec_ilv),
    .base_o     (base),
    .idx_o      (idx),
    .mask_o     (cur_mask),
    .ilv_o      (cur_ilv),
    .valid_o    (valid_o),
    .last_o     (last_o)
  );

  sdram_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i(base),
    .idx_i (idx),
    .mask_i(cur_mask),
    .ilv_i (cur_ilv),
    .col_o (col_o)
  );
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= 1'b0;
    else if (start_i) page_q <= (bl_code_i == 3'b111);
  end

  p_start_beat0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_last_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_page_no_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q) |-> !last_o);

  p_page_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q && !start_i && !term_i) |=>
      (valid_o && col_o == COL_W'($past(col_o) + COL_W'(1))));

  p_term_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> (!valid_o && !last_o));

  p_last_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> (!valid_o && $stable(col_o)));
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .bl_code_i  (bl_code_i),
  .term_i     (term_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/sdram_col_seq_bench.sv
module sdram_col_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sdram_col_seq u_sdram_col_seq (.*);

  // {col[79:72], code[71:69], ilv[68], len[67:64], beats[63:0], beat0 in [7:0]}
  localparam logic [79:0] VEC [8] = '{
    {8'h05, 3'b010, 1'b0, 4'd4, 32'h0, 32'h04070605},           // R4
    {8'h05, 3'b010, 1'b1, 4'd4, 32'h0, 32'h06070405},           // R5
    {8'h3E, 3'b011, 1'b0, 4'd8, 64'h3D3C3B3A39383F3E},          // R4
    {8'h3E, 3'b011, 1'b1, 4'd8, 64'h39383B3A3D3C3F3E},          // R5
    {8'hA1, 3'b001, 1'b0, 4'd2, 48'h0, 16'hA0A1},               // R4
    {8'hA1, 3'b000, 1'b0, 4'd1, 56'h0, 8'hA1},                  // R3
    {8'h77, 3'b101, 1'b1, 4'd1, 56'h0, 8'h77},                  // R3 reserved
    {8'hFF, 3'b001, 1'b1, 4'd2, 48'h0, 16'hFEFF}                // R5
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] c, input logic [2:0] b, input logic il, input logic t);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = c; bl_code_i = b; interleave_i = il; term_i = t;
    @(negedge clk_i);
    start_i = 1'b0; term_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 last in reset", int'(last_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check("R1 valid after reset", int'(valid_o), 0);
    check("R1 col after reset", int'(col_o), 0);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      int len;
      len = int'(VEC[v][67:64]);
      fire(VEC[v][79:72], VEC[v][71:69], VEC[v][68], 1'b0);
      for (int k = 0; k < len; k++) begin
        if (k > 0) @(negedge clk_i);
        check("R2 valid during burst", int'(valid_o), 1);
        check("R4/R5 beat column", int'(col_o), int'(VEC[v][k*8 +: 8]));
        check("R7 last flag", int'(last_o), (k == len - 1) ? 1 : 0);
      end
      @(negedge clk_i);
      check("R3 valid ends after length", int'(valid_o), 0);
    end

    // R6 full page, interleave ignored, wraps and runs past 256 beats
    fire(8'hFE, 3'b111, 1'b1, 1'b0);
    check("R6 page beat0", int'(col_o), 'hFE);
    @(negedge clk_i); check("R6 page beat1", int'(col_o), 'hFF);
    @(negedge clk_i); check("R6 page wrap", int'(col_o), 'h00);
    @(negedge clk_i); check("R6 page beat3", int'(col_o), 'h01);
    begin
      int bad_last = 0;
      int bad_valid = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk_i);
        if (last_o) bad_last++;
        if (!valid_o) bad_valid++;
      end
      check("R7 no last in page mode", bad_last, 0);
      check("R6 page keeps running", bad_valid, 0);
      // beat 303 -> (0xFE + 303) mod 256 = 0x2D
      check("R6 page column after long run", int'(col_o), 'h2D);
    end
    @(negedge clk_i); term_i = 1'b1;
    @(negedge clk_i); term_i = 1'b0;
    check("R8 term ends page", int'(valid_o), 0);

    // R8 term mid fixed burst
    fire(8'h10, 3'b011, 1'b0, 1'b0);
    @(negedge clk_i); term_i = 1'b1;
    @(negedge clk_i); term_i = 1'b0;
    check("R8 term mid burst valid", int'(valid_o), 0);
    check("R8 term mid burst last", int'(last_o), 0);

    // R10 term while idle
    @(negedge clk_i); term_i = 1'b1;
    @(negedge clk_i); term_i = 1'b0;
    check("R10 idle term valid", int'(valid_o), 0);
    check("R10 idle term col", int'(col_o), 'h11);

    // R9 restart mid burst with new length and order
    fire(8'h10, 3'b011, 1'b0, 1'b0);
    @(negedge clk_i);
    check("R9 before restart", int'(col_o), 'h11);
    fire(8'h45, 3'b010, 1'b1, 1'b0);
    check("R9 restart beat0", int'(col_o), 'h45);
    @(negedge clk_i); check("R9 restart beat1", int'(col_o), 'h44);
    @(negedge clk_i); check("R9 restart beat2", int'(col_o), 'h47);
    @(negedge clk_i); check("R9 restart beat3", int'(col_o), 'h46);
    check("R9 restart last", int'(last_o), 1);
    @(negedge clk_i); check("R9 restart ends", int'(valid_o), 0);

    // R8 start and term together: start wins
    fire(8'h80, 3'b001, 1'b0, 1'b1);
    check("R8 start beats term valid", int'(valid_o), 1);
    check("R8 start beats term col", int'(col_o), 'h80);
    @(negedge clk_i); check("R8 start beats term beat1", int'(col_o), 'h81);
    check("R8 start beats term last", int'(last_o), 1);

    // R1 async reset mid burst
    fire(8'h20, 3'b011, 1'b0, 1'b0);
    #2 rst_ni = 1'b0;
    #1 check("R1 reset clears valid", int'(valid_o), 0);
    check("R1 reset clears col", int'(col_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule